// File: doc/BRIEF.md
# Masked Priority Interrupt Source Encoder

This block gathers up to sixteen level-sensitive interrupt lines from devices into one combined interrupt request. A source register copies the line levels on every clock. A software-writable enable mask selects which lines may take part. The combined request is high whenever an enabled source is active.

Software reaches the block through a small 16-bit register window. The word at byte offset 0x00 is read-only. It returns an encoded vector naming the lowest-numbered line that is both active and enabled. The word at byte offset 0x02 holds the enable mask. The mask accepts full-word writes, and byte-lane writes that leave the other lane unchanged.

Top module: `masked_irq_encoder`

## Requirements
- R1: Source bit i is captured from `irq_in[i]` on every rising clock edge. It is 1 while the line is high and 0 once the line is low. It therefore shows in the vector read one cycle after the line changes.
- R2: The pending set is the source bits ANDed with the enable mask. `irq_out` is high exactly when the pending set is non-zero. `irq_out` is registered and reflects a line or mask change one clock after it.
- R3: A read at byte offset 0x00 (word index 0) returns (i+1)<<2 for the lowest-numbered pending bit i. For example, bit 0 gives 0x0004, bit 4 gives 0x0014 and bit 15 gives 0x0040. It returns 0x0000 when nothing is pending.
- R4: The enable mask lives at byte offset 0x02 (word index 1). Mask bit i enables line i. With `byte_en` = 2'b11 a write replaces the whole mask, and a read returns the mask.
- R5: `byte_en[0]` selects mask bits 7:0 and `byte_en[1]` selects mask bits 15:8. A lane that is not selected keeps its previous value.
- R6: A synchronous reset sets the mask to 0x0010, clears all source bits and drives `irq_out` low.
- R7: Writes to offset 0x00 change neither the mask nor the vector.
- R8: Reads at any word index other than 0 or 1 return 0x0000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | NUM_SRC | Level-sensitive device interrupt lines |
| wr_en | input | 1 | Register write strobe |
| byte_en | input | 2 | Byte-lane select for writes |
| addr | input | ADDR_W | Byte address into the register window |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for `addr`, combinational from registered state |
| irq_out | output | 1 | Registered combined interrupt request |

## Verification
A mask write and a change of line level can land on the same clock edge. The combined output must then use the newly written mask together with the newly sampled levels. It must not use a mix of old and new values.

The bench provokes this in three ways:
- It enables a line in the same step that raises it.
- It masks a line in the same step that a lower line drops.
- It does a byte write that re-enables one lane while the line levels change.

In each case it judges the registered output, and the vector read one cycle later, against its own model of mask and levels.

// File: rtl/irq_enc_pkg.sv
package irq_enc_pkg;
    localparam int BUS_W  = 16;
    localparam int LANE_W = 8;
    localparam int NUM_LANES = BUS_W / LANE_W;

    typedef enum logic [1:0] {
        SEL_VECTOR = 2'd0,
        SEL_MASK   = 2'd1,
        SEL_NONE   = 2'd2
    } reg_sel_e;

    typedef struct packed {
        logic                 wr;
        logic [NUM_LANES-1:0] lanes;
        logic [BUS_W-1:0]     data;
    } wr_req_t;

    function automatic reg_sel_e decode_word(input logic [31:0] byte_addr);
        logic [31:0] word;
        word = byte_addr >> 1;
        if (word == 32'd0)      return SEL_VECTOR;
        else if (word == 32'd1) return SEL_MASK;
        else                    return SEL_NONE;
    endfunction

    function automatic logic [BUS_W-1:0] vec_code(input int idx);
        return BUS_W'((idx + 1) << 2);
    endfunction
endpackage

// File: rtl/irq_src_reg.sv
module irq_src_reg #(
    parameter int N = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] lines,
    output logic [N-1:0] src_q
);
    always_ff @(posedge clk) begin
        if (rst) src_q <= '0;
        else     src_q <= lines;
    end
endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg
    import irq_enc_pkg::*;
#(
    parameter int          N   = 16,
    parameter logic [15:0] RST = 16'h0010
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         hit,
    input  wr_req_t      req,
    output logic [N-1:0] mask_d,
    output logic [N-1:0] mask_q
);
    for (genvar b = 0; b < N; b++) begin : g_bit
        localparam int LANE = b / LANE_W;
        assign mask_d[b] = (req.wr && hit && req.lanes[LANE]) ? req.data[b] : mask_q[b];
    end

    always_ff @(posedge clk) begin
        if (rst) mask_q <= RST[N-1:0];
        else     mask_q <= mask_d;
    end
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc
    import irq_enc_pkg::*;
#(
    parameter int N = 16
) (
    input  logic [N-1:0]     pend,
    output logic [BUS_W-1:0] code
);
    always_comb begin
        code = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (pend[i]) code = vec_code(i);
        end
    end
endmodule

// File: rtl/masked_irq_encoder.sv
module masked_irq_encoder
    import irq_enc_pkg::*;
#(
    parameter int          NUM_SRC  = 16,
    parameter int          ADDR_W   = 4,
    parameter logic [15:0] MASK_RST = 16'h0010
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] irq_in,
    input  logic               wr_en,
    input  logic [1:0]         byte_en,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [15:0]        wdata,
    output logic [15:0]        rdata,
    output logic               irq_out
);
    reg_sel_e           sel;
    wr_req_t            req;
    logic [NUM_SRC-1:0] src_q;
    logic [NUM_SRC-1:0] mask_q;
    logic [NUM_SRC-1:0] mask_d;
    logic [BUS_W-1:0]   vec;
    logic               irq_q;

    assign sel = decode_word(32'(addr));
    assign req = '{wr: wr_en, lanes: byte_en, data: wdata};

    irq_src_reg #(.N(NUM_SRC)) u_src (
        .clk   (clk),
        .rst   (rst),
        .lines (irq_in),
        .src_q (src_q)
    );

    irq_mask_reg #(.N(NUM_SRC), .RST(MASK_RST)) u_mask (
        .clk    (clk),
        .rst    (rst),
        .hit    (sel == SEL_MASK),
        .req    (req),
        .mask_d (mask_d),
        .mask_q (mask_q)
    );

    irq_prio_enc #(.N(NUM_SRC)) u_enc (
        .pend (src_q & mask_q),
        .code (vec)
    );

    always_ff @(posedge clk) begin
        if (rst) irq_q <= 1'b0;
        else     irq_q <= |(irq_in & mask_d);
    end
    assign irq_out = irq_q;

    always_comb begin
        unique case (sel)
            SEL_VECTOR: rdata = vec;
            SEL_MASK:   rdata = BUS_W'(mask_q);
            default:    rdata = '0;
        endcase
    end
endmodule

// File: rtl/masked_irq_encoder_chk.sv
module masked_irq_encoder_chk #(
    parameter int          NUM_SRC  = 16,
    parameter int          ADDR_W   = 4,
    parameter logic [15:0] MASK_RST = 16'h0010
) (
    input logic               clk,
    input logic               rst,
    input logic [NUM_SRC-1:0] irq_in,
    input logic               wr_en,
    input logic [1:0]         byte_en,
    input logic [ADDR_W-1:0]  addr,
    input logic [15:0]        rdata,
    input logic               irq_out,
    input logic [NUM_SRC-1:0] src_q,
    input logic [NUM_SRC-1:0] mask_q
);
    logic [ADDR_W-1:0] word;
    assign word = addr >> 1;

    a_r1_src_tracks_line: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> src_q == $past(irq_in));

    a_r2_out_matches_pending: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> irq_out == |(src_q & mask_q));

    a_r3_vector_agrees_out: assert property (@(posedge clk) disable iff (rst)
        (word == '0) |-> ((rdata != 16'h0) == irq_out));

    a_r5_low_lane_keeps_high: assert property (@(posedge clk) disable iff (rst)
        (wr_en && word == ADDR_W'(1) && byte_en == 2'b01)
        |=> (mask_q >> 8) == ($past(mask_q) >> 8));

    a_r6_reset_state: assert property (@(posedge clk)
        rst |=> (mask_q == MASK_RST[NUM_SRC-1:0] && src_q == '0 && !irq_out));

    a_r7_vector_write_ignored: assert property (@(posedge clk) disable iff (rst)
        (wr_en && word == '0) |=> $stable(mask_q));

    a_r8_unmapped_zero: assert property (@(posedge clk) disable iff (rst)
        (word > ADDR_W'(1)) |-> rdata == 16'h0);
endmodule

bind masked_irq_encoder masked_irq_encoder_chk #(
    .NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W), .MASK_RST(MASK_RST)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .irq_in  (irq_in),
    .wr_en   (wr_en),
    .byte_en (byte_en),
    .addr    (addr),
    .rdata   (rdata),
    .irq_out (irq_out),
    .src_q   (src_q),
    .mask_q  (mask_q)
);

// File: tb/masked_irq_encoder_tb.sv
`timescale 1ns/1ps
module masked_irq_encoder_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] irq_in = '0;
    logic        wr_en = 1'b0;
    logic [1:0]  byte_en = 2'b00;
    logic [3:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        irq_out;

    always #5 clk = ~clk;

    masked_irq_encoder u_dut (
        .clk(clk), .rst(rst), .irq_in(irq_in), .wr_en(wr_en), .byte_en(byte_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .irq_out(irq_out)
    );

    logic [15:0] q_rd[$];
    logic        q_irq[$];
    string       q_tag[$];
    int          applied = 0;
    int          miss = 0;
    bit          done = 0;
    logic [15:0] m_src  = 16'h0000;
    logic [15:0] m_mask = 16'h0010;

    function automatic logic [15:0] model_vec(input logic [15:0] p);
        for (int i = 0; i < 16; i++) begin
            if (p[i]) return 16'((i + 1) * 4);
        end
        return 16'h0;
    endfunction

    task automatic step(input logic [15:0] lines, input bit wr, input logic [1:0] be,
                        input logic [3:0] waddr, input logic [15:0] wd,
                        input logic [3:0] raddr, input string tag);
        logic [15:0] exp_rd;
        @(negedge clk); #1;
        irq_in = lines; wr_en = wr; byte_en = be; addr = waddr; wdata = wd;
        if (wr && (waddr >> 1) == 4'd1) begin
            if (be[0]) m_mask[7:0]  = wd[7:0];
            if (be[1]) m_mask[15:8] = wd[15:8];
        end
        m_src = lines;
        @(posedge clk); #1;
        wr_en = 1'b0; addr = raddr;
        case (raddr >> 1)
            4'd0:    exp_rd = model_vec(m_src & m_mask);
            4'd1:    exp_rd = m_mask;
            default: exp_rd = 16'h0;
        endcase
        q_rd.push_back(exp_rd);
        q_irq.push_back(|(m_src & m_mask));
        q_tag.push_back(tag);
    endtask

    always @(negedge clk) begin
        while (q_rd.size() > 0) begin
            logic [15:0] er;
            logic        ei;
            string       t;
            er = q_rd.pop_front();
            ei = q_irq.pop_front();
            t  = q_tag.pop_front();
            applied++;
            if (rdata !== er) begin
                miss++;
                $display("FAIL %s rdata actual=%h expected=%h", t, rdata, er);
            end
            if (irq_out !== ei) begin
                miss++;
                $display("FAIL %s irq_out actual=%b expected=%b", t, irq_out, ei);
            end
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        step(16'h0000, 0, 2'b00, 4'h0, 16'h0, 4'h2, "R6 reset mask");
        step(16'h0000, 0, 2'b00, 4'h0, 16'h0, 4'h0, "R6 reset vector");
        step(16'h0001, 0, 2'b00, 4'h0, 16'h0, 4'h0, "R2 masked line");
        step(16'h0011, 0, 2'b00, 4'h0, 16'h0, 4'h0, "R1 enabled line 4");
        step(16'h0000, 0, 2'b00, 4'h0, 16'h0, 4'h0, "R1 line drops");
        step(16'h0000, 1, 2'b11, 4'h2, 16'hFFFF, 4'h2, "R4 full mask write");
        step(16'h8001, 0, 2'b00, 4'h0, 16'h0, 4'h0, "R3 lowest wins bit0");
        step(16'h8000, 0, 2'b00, 4'h0, 16'h0, 4'h0, "R3 top bit 15");
        step(16'h0A00, 0, 2'b00, 4'h0, 16'h0, 4'h0, "R3 bit 9 of two");
        step(16'h8000, 1, 2'b01, 4'h2, 16'h33AA, 4'h2, "R5 low lane only");
        step(16'h8000, 1, 2'b10, 4'h3, 16'h12CC, 4'h2, "R5 high lane only");
        step(16'h8000, 0, 2'b00, 4'h0, 16'h0, 4'h0, "R2 line 15 now masked");
        step(16'h0002, 1, 2'b11, 4'h0, 16'h0000, 4'h2, "R7 write to vector word");
        step(16'h0002, 0, 2'b00, 4'h0, 16'h0, 4'h0, "R7 vector intact");
        step(16'h0000, 0, 2'b00, 4'h0, 16'h0, 4'h4, "R8 word 2");
        step(16'h0002, 0, 2'b00, 4'h0, 16'h0, 4'hE, "R8 word 7");
        step(16'h0004, 1, 2'b11, 4'h2, 16'h0004, 4'h0, "R2 same-cycle enable and raise");
        step(16'h0000, 1, 2'b11, 4'h2, 16'h0000, 4'h0, "R2 same-cycle mask and drop");
        step(16'h0100, 1, 2'b10, 4'h2, 16'h0100, 4'h0, "R5 lane re-enable with line");
        step(16'h0100, 0, 2'b00, 4'h0, 16'h0, 4'h2, "R4 mask readback");
        @(negedge clk); #1 rst = 1'b1;
        @(posedge clk); #1 rst = 1'b0;
        m_mask = 16'h0010; m_src = 16'h0000;
        step(16'h0010, 0, 2'b00, 4'h0, 16'h0, 4'h0, "R6 after second reset");
        @(negedge clk);
        @(negedge clk);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", applied, miss);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            miss++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", applied, miss);
            $finish;
        end
    end
endmodule